// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is the digital I/O port of a small 8-bit microcontroller. The CPU sees an 8-bit port register and a separate direction register. Four pads sit on the other side. The port holds an output latch and a direction mask, and drives an output value and an output enable to each pad.

A port read returns the synchronized levels on the pads, never the latch. It does this even for pins that are driving. Three of the pins are shared with other functions: analog inputs, a timer clock input and a divided clock output. The block decides which function owns each shared pin. Pin 3 is input-only, and it can be given to the chip's external reset.

The port also produces weak pull-up enables. It raises a sticky wake flag when a monitored pin moves away from the level seen at the last port read.

Top module: `gpio_port4`

## Requirements
- R1: After reset the direction mask is all ones, so every `pad_oe` bit is 0. The output latch is 0 and `wake_flag` is 0.
- R2: `rdata[7:4]` always reads 0. `rdata[3:0]` shows the pad levels through a two-flop synchronizer, two clock edges after the pads change. This holds whatever the direction or the latch, unless R5, R6 or R7 force a bit to 0.
- R3: A pulse on `dir_wr` loads `wdata[3:0]` into the direction mask at the next edge. Bit n = 1 turns pad n's driver off. Bit n = 0 enables the driver on a pin owned by digital I/O.
- R4: A pulse on `port_wr` loads `wdata[3:0]` into the output latch at the next edge. `pad_out[n]` carries latch bit n on every digital-I/O-owned pin 0 to 2. The latch holds its value otherwise, including across direction writes.
- R5: Pin 3 never drives: `pad_oe[3]` and `pad_out[3]` are always 0. When `cfg_rstpin` is 1, `rdata[3]` reads 0.
- R6: When `cfg_ana[0]` (pin 0) or `cfg_ana[1]` (pin 1) is 1, that pin's `pad_oe` and `pad_out` are 0 and its `rdata` bit reads 0.
- R7: Pin 2 ownership uses a fixed priority. When `cfg_clkout_en` is 1, the pin drives `clk_q_in` with the enable forced on. Otherwise, when `cfg_tmr_ext` is 1, the pin is an input and its read still shows the pad. Otherwise, when `cfg_ana[2]` is 1, the pin is an input and reads 0. Otherwise the direction bit and the latch control it.
- R8: `pullup_en` bits 0, 1 and 3 all equal `cfg_pullup_en`, and bit 2 is always 0.
- R9: When `cfg_wake_en` is 1, `wake_flag` rises on the edge after a synchronized level on pin 0, 1 or 3 differs from the snapshot. Pin 3 is not monitored while `cfg_rstpin` is 1, and changes on pin 2 are never seen.
- R10: A `port_rd` pulse clears `wake_flag` at the next edge and copies the synchronized levels into the snapshot. Until then the flag stays set.
- R11: While `cfg_wake_en` is 0, a clear `wake_flag` stays clear, whatever the pads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wdata | input | 8 | Write data from the working register |
| port_wr | input | 1 | Write strobe for the output latch |
| dir_wr | input | 1 | Write strobe for the direction mask |
| port_rd | input | 1 | Read strobe; takes the wake snapshot and clears the flag |
| rdata | output | 8 | Port read value |
| pad_in | input | 4 | Pad input levels |
| clk_q_in | input | 1 | Divided clock routed to pin 2 when clock output is on |
| cfg_rstpin | input | 1 | Pin 3 serves as the external reset input |
| cfg_pullup_en | input | 1 | Common weak pull-up enable |
| cfg_wake_en | input | 1 | Common wake-on-change enable |
| cfg_clkout_en | input | 1 | Drive the divided clock on pin 2 |
| cfg_tmr_ext | input | 1 | Pin 2 feeds the timer clock |
| cfg_ana | input | 3 | Analog select for pins 0, 1, 2 |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| pullup_en | output | 4 | Weak pull-up enables |
| wake_flag | output | 1 | Sticky wake-on-change flag |

## Verification
The assertions check several rules on every cycle. Register loads and holds for both the latch and the direction mask are checked, as is the clock-output override on pin 2 and the analog driver cut-off. The wake flag's clear, sticky and disabled behaviour is also covered. Only the bench scenarios can show the read path: the two-edge synchronizer latency, pads overriding a driven latch value, and the zero bits forced by analog and reset-pin modes. The same applies to the full pin 2 priority across combinations, and to which pins the wake snapshot actually monitors.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPIN = 4;

  typedef enum logic [1:0] {
    OWN_GPIO   = 2'd0,
    OWN_CLKOUT = 2'd1,
    OWN_TMR    = 2'd2,
    OWN_ANA    = 2'd3
  } owner_e;

  // Pin 2 priority: clock output, timer input, analog, digital I/O.
  function automatic owner_e pin2_owner(input logic clkout, input logic tmr,
                                        input logic ana);
    if (clkout)   return OWN_CLKOUT;
    else if (tmr) return OWN_TMR;
    else if (ana) return OWN_ANA;
    else          return OWN_GPIO;
  endfunction

  // Pins watched for change: 0, 1 and 3 (3 only outside reset-pin mode).
  function automatic logic [NPIN-1:0] wake_mask(input logic rstpin);
    return {~rstpin, 1'b0, 1'b1, 1'b1};
  endfunction

  // Pull-up enables: one common switch for pins 0, 1 and 3.
  function automatic logic [NPIN-1:0] pullup_map(input logic en);
    return {en, 1'b0, en, en};
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pkg::*;
(
  input  logic [NPIN-1:0] dir_mask,
  input  logic [NPIN-1:0] latch,
  input  logic [NPIN-1:0] pins_s,
  input  logic            clk_q_in,
  input  logic            cfg_rstpin,
  input  logic            cfg_clkout_en,
  input  logic            cfg_tmr_ext,
  input  logic [2:0]      cfg_ana,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] rd_view,
  output owner_e          p2_owner
);
  assign p2_owner = pin2_owner(cfg_clkout_en, cfg_tmr_ext, cfg_ana[2]);

  // Pins 0 and 1: analog select or digital I/O.
  for (genvar i = 0; i < 2; i++) begin : g_ana_pin
    always_comb begin
      if (cfg_ana[i]) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
        rd_view[i] = 1'b0;
      end else begin
        pad_oe[i]  = ~dir_mask[i];
        pad_out[i] = latch[i];
        rd_view[i] = pins_s[i];
      end
    end
  end

  // Pin 2: four possible owners.
  always_comb begin
    unique case (p2_owner)
      OWN_CLKOUT: begin
        pad_oe[2]  = 1'b1;
        pad_out[2] = clk_q_in;
        rd_view[2] = pins_s[2];
      end
      OWN_TMR: begin
        pad_oe[2]  = 1'b0;
        pad_out[2] = 1'b0;
        rd_view[2] = pins_s[2];
      end
      OWN_ANA: begin
        pad_oe[2]  = 1'b0;
        pad_out[2] = 1'b0;
        rd_view[2] = 1'b0;
      end
      default: begin
        pad_oe[2]  = ~dir_mask[2];
        pad_out[2] = latch[2];
        rd_view[2] = pins_s[2];
      end
    endcase
  end

  // Pin 3: input only.
  assign pad_oe[3]  = 1'b0;
  assign pad_out[3] = 1'b0;
  assign rd_view[3] = cfg_rstpin ? 1'b0 : pins_s[3];
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake
  import gpio_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pins_s,
  input  logic            port_rd,
  input  logic            cfg_wake_en,
  input  logic            cfg_rstpin,
  output logic            wake_flag,
  output logic            change_hit
);
  logic [NPIN-1:0] snap;
  logic [NPIN-1:0] watch;

  assign watch      = wake_mask(cfg_rstpin);
  assign change_hit = cfg_wake_en & (|((pins_s ^ snap) & watch));

  always_ff @(posedge clk) begin
    if (rst) begin
      snap      <= '0;
      wake_flag <= 1'b0;
    end else if (port_rd) begin
      snap      <= pins_s;
      wake_flag <= 1'b0;
    end else if (change_hit) begin
      wake_flag <= 1'b1;
    end
  end

  AST_WAKE_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (rst)
    port_rd |=> !wake_flag); // R10
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wake_flag && !port_rd) |=> wake_flag); // R10
  AST_WAKE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wake_flag && !cfg_wake_en) |=> !wake_flag); // R11
  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (rst)
    (change_hit && !port_rd) |=> wake_flag); // R9
endmodule

// File: rtl/gpio_port4.sv
module gpio_port4
  import gpio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   wdata,
  input  logic            port_wr,
  input  logic            dir_wr,
  input  logic            port_rd,
  output logic [DW-1:0]   rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic            clk_q_in,
  input  logic            cfg_rstpin,
  input  logic            cfg_pullup_en,
  input  logic            cfg_wake_en,
  input  logic            cfg_clkout_en,
  input  logic            cfg_tmr_ext,
  input  logic [2:0]      cfg_ana,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pullup_en,
  output logic            wake_flag
);
  logic [NPIN-1:0] latch_q;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] pins_s;
  logic [NPIN-1:0] rd_view;
  owner_e          p2_owner;
  logic            change_hit;
  logic            unused_hi;

  assign unused_hi = ^wdata[DW-1:NPIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else begin
      if (port_wr) latch_q <= wdata[NPIN-1:0];
      if (dir_wr)  dir_q   <= wdata[NPIN-1:0];
    end
  end

  gpio_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pins_s)
  );

  gpio_pinmux u_mux (
    .dir_mask      (dir_q),
    .latch         (latch_q),
    .pins_s        (pins_s),
    .clk_q_in      (clk_q_in),
    .cfg_rstpin    (cfg_rstpin),
    .cfg_clkout_en (cfg_clkout_en),
    .cfg_tmr_ext   (cfg_tmr_ext),
    .cfg_ana       (cfg_ana),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .rd_view       (rd_view),
    .p2_owner      (p2_owner)
  );

  gpio_wake u_wake (
    .clk         (clk),
    .rst         (rst),
    .pins_s      (pins_s),
    .port_rd     (port_rd),
    .cfg_wake_en (cfg_wake_en),
    .cfg_rstpin  (cfg_rstpin),
    .wake_flag   (wake_flag),
    .change_hit  (change_hit)
  );

  assign rdata     = {{(DW-NPIN){1'b0}}, rd_view};
  assign pullup_en = pullup_map(cfg_pullup_en);

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> dir_q == $past(wdata[NPIN-1:0])); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dir_wr |=> $stable(dir_q)); // R3
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> latch_q == $past(wdata[NPIN-1:0])); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !port_wr |=> $stable(latch_q)); // R4
  AST_CLKOUT_WINS: assert property (@(posedge clk) disable iff (rst)
    cfg_clkout_en |-> (p2_owner == OWN_CLKOUT && pad_oe[2] && pad_out[2] == clk_q_in)); // R7
  AST_ANA_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (cfg_ana[0] |-> !pad_oe[0]) and (cfg_ana[1] |-> !pad_oe[1])); // R6
endmodule

// File: tb/sim_gpio_port4.sv
module sim_gpio_port4;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wdata = '0;
  logic       port_wr = 0, dir_wr = 0, port_rd = 0;
  logic [7:0] rdata;
  logic [3:0] pad_in = '0;
  logic       clk_q_in = 1'b1;
  logic       cfg_rstpin = 0, cfg_pullup_en = 0, cfg_wake_en = 0;
  logic       cfg_clkout_en = 0, cfg_tmr_ext = 0;
  logic [2:0] cfg_ana = '0;
  logic [3:0] pad_out, pad_oe, pullup_en;
  logic       wake_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  gpio_port4 u0 (
    .clk(clk), .rst(rst), .wdata(wdata), .port_wr(port_wr), .dir_wr(dir_wr),
    .port_rd(port_rd), .rdata(rdata), .pad_in(pad_in), .clk_q_in(clk_q_in),
    .cfg_rstpin(cfg_rstpin), .cfg_pullup_en(cfg_pullup_en),
    .cfg_wake_en(cfg_wake_en), .cfg_clkout_en(cfg_clkout_en),
    .cfg_tmr_ext(cfg_tmr_ext), .cfg_ana(cfg_ana), .pad_out(pad_out),
    .pad_oe(pad_oe), .pullup_en(pullup_en), .wake_flag(wake_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_dir(input logic [3:0] v);
    wdata = {4'h0, v}; dir_wr = 1; @(negedge clk); dir_wr = 0;
  endtask
  task automatic pulse_port(input logic [3:0] v);
    wdata = {4'hA, v}; port_wr = 1; @(negedge clk); port_wr = 0;
  endtask
  task automatic pulse_rd();
    port_rd = 1; @(negedge clk); port_rd = 0;
  endtask

  // {dir, latch, clkout, tmr, ana[2:0], rstpin, pad, exp_oe, exp_out, exp_rd}
  localparam logic [29:0] TBL [0:6] = '{
    {4'b0000, 4'b1010, 1'b0, 1'b0, 3'b000, 1'b0, 4'b0101, 4'b0111, 4'b0010, 4'b0101},
    {4'b1111, 4'b0101, 1'b0, 1'b0, 3'b000, 1'b0, 4'b1010, 4'b0000, 4'b0101, 4'b1010},
    {4'b0000, 4'b1111, 1'b0, 1'b0, 3'b011, 1'b0, 4'b1111, 4'b0100, 4'b0100, 4'b1100},
    {4'b0000, 4'b1111, 1'b1, 1'b1, 3'b100, 1'b0, 4'b0000, 4'b0111, 4'b0111, 4'b0000},
    {4'b0000, 4'b0100, 1'b0, 1'b1, 3'b100, 1'b0, 4'b0100, 4'b0011, 4'b0000, 4'b0100},
    {4'b0000, 4'b0100, 1'b0, 1'b0, 3'b100, 1'b0, 4'b0100, 4'b0011, 4'b0000, 4'b0000},
    {4'b0000, 4'b1111, 1'b0, 1'b0, 3'b000, 1'b1, 4'b1000, 4'b0111, 4'b0111, 4'b0000}
  };

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual hung expected finish");
          $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    wait_n(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {4'h0, pad_oe}, 8'h00);
    chk("R1 out", {4'h0, pad_out}, 8'h00);
    chk("R1 wake", {7'h0, wake_flag}, 8'h00);

    // R2 two-edge latency: after one edge still old, after two new
    pad_in = 4'b1011;
    @(negedge clk);
    chk("R2 latency1", rdata, 8'h00);
    @(negedge clk);
    chk("R2 latency2", rdata, 8'h0B);

    // Table walk: R3 R4 R5 R6 R7 R2
    for (int k = 0; k < 7; k++) begin
      logic [29:0] v;
      v = TBL[k];
      pulse_dir(v[29:26]);
      pulse_port(v[25:22]);
      cfg_clkout_en = v[21];
      cfg_tmr_ext   = v[20];
      cfg_ana       = v[19:17];
      cfg_rstpin    = v[16];
      pad_in        = v[15:12];
      wait_n(3);
      chk($sformatf("R3/R6/R7 oe row%0d", k), {4'h0, pad_oe}, {4'h0, v[11:8]});
      chk($sformatf("R4/R5 out row%0d", k), {4'h0, pad_out}, {4'h0, v[7:4]});
      chk($sformatf("R2/R5 rd row%0d", k), rdata, {4'h0, v[3:0]});
    end
    cfg_clkout_en = 0; cfg_tmr_ext = 0; cfg_ana = '0; cfg_rstpin = 0;

    // R7 clock output follows clk_q_in
    cfg_clkout_en = 1; clk_q_in = 0;
    #1 chk("R7 clkout low", {7'h0, pad_out[2]}, 8'h00);
    cfg_clkout_en = 0; clk_q_in = 1;

    // R4 latch holds across direction writes
    pulse_port(4'b0110);
    pulse_dir(4'b0000);
    pulse_dir(4'b1010);
    wait_n(1);
    chk("R4 hold", {4'h0, pad_out}, 8'h06);
    chk("R3 dir 1010", {4'h0, pad_oe}, 8'h05);

    // R2 pin driven high but pad low reads 0
    pulse_dir(4'b0000);
    pulse_port(4'b0111);
    pad_in = 4'b0000;
    wait_n(3);
    chk("R2 pad overrides latch", rdata, 8'h00);

    // R8 pull-ups
    cfg_pullup_en = 1; #1 chk("R8 on", {4'h0, pullup_en}, 8'h0B);
    cfg_pullup_en = 0; #1 chk("R8 off", {4'h0, pullup_en}, 8'h00);

    // R9 / R10 wake
    @(negedge clk);
    cfg_wake_en = 1;
    pulse_rd();
    wait_n(2);
    chk("R10 no change stays low", {7'h0, wake_flag}, 8'h00);
    pad_in = 4'b0010;
    wait_n(4);
    chk("R9 pin1 change", {7'h0, wake_flag}, 8'h01);
    wait_n(3);
    chk("R10 sticky", {7'h0, wake_flag}, 8'h01);
    pulse_rd();
    chk("R10 cleared", {7'h0, wake_flag}, 8'h00);
    wait_n(3);
    chk("R10 snapshot taken", {7'h0, wake_flag}, 8'h00);
    pad_in = 4'b0110;
    wait_n(4);
    chk("R9 pin2 not watched", {7'h0, wake_flag}, 8'h00);
    cfg_rstpin = 1;
    pad_in = 4'b1110;
    wait_n(4);
    chk("R9 pin3 masked in reset mode", {7'h0, wake_flag}, 8'h00);
    cfg_rstpin = 0;
    wait_n(1);
    chk("R9 pin3 watched", {7'h0, wake_flag}, 8'h01);
    pulse_rd();
    cfg_wake_en = 0;
    pad_in = 4'b0001;
    wait_n(4);
    chk("R11 disabled", {7'h0, wake_flag}, 8'h00);

    // R1 reset again restores direction and latch
    rst = 1; wait_n(1); rst = 0;
    chk("R1 oe after reset", {4'h0, pad_oe}, 8'h00);
    chk("R1 latch after reset", {4'h0, pad_out}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule